// File: doc/BRIEF.md
# Configurable Three-Input Logic Cell

This block is a small programmable logic element that sits beside a group of general-purpose pins. Three external lines, called A, B and C, are first brought into the clock domain. Each line then has an enable gate and an optional inversion. The conditioned signals feed one function that a 3-bit select code chooses. The choices are a constant low, AND, OR, XOR, or a storage flip-flop with direct set and clear. An output inverter and an output enable follow the function, and a register drives the line Y.

A configuration bit sets the gate width. When it is set, the AND, OR and XOR gates use all three inputs. When it is clear, they use only A and B. Each time Y changes, the cell can raise a one-clock event pulse carrying a fixed 5-bit source code, which an external event queue can capture. It also drives a level interrupt that is active while Y sits at a chosen level. All configuration arrives on plain input ports.

Top module: `tri_logic_cell`

## Requirements
- R1: While `rst_n` is low, `y_out`, `evt_valid` and `evt_code` are 0, and `irq` equals `out_en & ~irq_level`.
- R2: Each raw input passes through two synchronizer flops. A change on `in_raw` reaches `y_out` on the third rising clock edge after it is applied.
- R3: Input i (bit 0 = A, bit 1 = B, bit 2 = C) reads as 0 when `in_en[i]` is 0. The value is then inverted when `in_inv[i]` is 1.
- R4: The `func_sel` codes are 000 constant low, 001 AND, 010 OR, 011 XOR and 100 flip-flop. Codes 101, 110 and 111 give a low function result.
- R5: With `use_c` = 1, the AND, OR and XOR gates include conditioned C. With `use_c` = 0, they use only conditioned A and B.
- R6: The flip-flop loads conditioned A on each rising edge of conditioned B. `ff_set` forces it to 1 and takes priority over `ff_clr`, which forces it to 0 and takes priority over a load. In mode 100, its state reaches `y_out` one edge after it updates.
- R7: When `inv_out` is 1, the function result is inverted before the output enable and the output register.
- R8: When `out_en` is 0, `y_out` goes low on the next edge, and neither `irq` nor an event is produced.
- R9: `irq` is high exactly while `out_en` is 1 and `y_out` equals `irq_level`.
- R10: If `event_en` and `out_en` are both 1, `evt_valid` is high for the one cycle in which `y_out` shows a new value, and `evt_code` then carries `EVT_CODE` (default 5'h11). At all other times both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_raw | input | 3 | Asynchronous input lines: bit 0 A, bit 1 B, bit 2 C |
| in_en | input | 3 | Per-input acceptance enable |
| in_inv | input | 3 | Per-input inversion |
| func_sel | input | 3 | Function select code |
| use_c | input | 1 | Include C in the gates |
| ff_set | input | 1 | Flip-flop set (highest priority) |
| ff_clr | input | 1 | Flip-flop clear |
| inv_out | input | 1 | Invert function result |
| out_en | input | 1 | Output enable |
| irq_level | input | 1 | Level of `y_out` that raises the interrupt |
| event_en | input | 1 | Enable event pulses |
| y_out | output | 1 | Registered cell output |
| irq | output | 1 | Level interrupt |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_code | output | 5 | Event source code, valid with `evt_valid` |

## Verification
A raw input change reaches `y_out` on the third rising edge. A change to select, inversion, `use_c` or `out_en` appears on the first edge. `ff_set` and `ff_clr` reach the flip-flop on the first edge and `y_out` on the second. `evt_valid` and `evt_code` update on the same edge as `y_out`, and `irq` follows `y_out` and its configuration within the same cycle. The bench advances its own model once per rising edge, using the inputs that were stable before that edge. It compares every output at the following falling edge and only then drives new stimulus, so each check sees exactly the edges the requirements count.

// File: rtl/lc_pkg.sv
package lc_pkg;

  localparam int LC_NIN = 3;

  typedef enum logic [2:0] {
    FN_LOW  = 3'b000,
    FN_AND  = 3'b001,
    FN_OR   = 3'b010,
    FN_XOR  = 3'b011,
    FN_FLOP = 3'b100
  } lc_fn_e;

  // condition one synchronized line: gate first, then invert
  function automatic logic lc_condition(input logic raw, input logic en, input logic inv);
    return (raw & en) ^ inv;
  endfunction

  // function result for a select code; reserved codes give 0
  function automatic logic lc_gate(input logic [2:0] sel, input logic use_c,
                                   input logic [LC_NIN-1:0] p, input logic ff_q);
    logic c_and;
    logic c_orx;
    logic res;
    c_and = use_c ? p[2] : 1'b1;
    c_orx = use_c ? p[2] : 1'b0;
    case (sel)
      FN_AND:  res = p[0] & p[1] & c_and;
      FN_OR:   res = p[0] | p[1] | c_orx;
      FN_XOR:  res = p[0] ^ p[1] ^ c_orx;
      FN_FLOP: res = ff_q;
      default: res = 1'b0;
    endcase
    return res;
  endfunction

  // flip-flop next state: set > clear > load on B rise
  function automatic logic lc_ff_next(input logic set, input logic clr, input logic rise,
                                      input logic d, input logic q);
    logic n;
    if (set)       n = 1'b1;
    else if (clr)  n = 1'b0;
    else if (rise) n = d;
    else           n = q;
    return n;
  endfunction

endpackage

// File: rtl/lc_sync.sv
module lc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] stg;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] src;
    if (g == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = stg[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= '0;
      else        stg[g] <= src;
    end
  end

  assign q = stg[LAST];

endmodule

// File: rtl/lc_func.sv
module lc_func
  import lc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LC_NIN-1:0] p,
  input  logic [2:0]        sel,
  input  logic              use_c,
  input  logic              ff_set,
  input  logic              ff_clr,
  output logic              f,
  output logic              ff_q,
  output logic              b_rise
);
  logic b_prev;
  logic ff_n;

  assign b_rise = p[1] & ~b_prev;
  assign ff_n   = lc_ff_next(ff_set, ff_clr, b_rise, p[0], ff_q);
  assign f      = lc_gate(sel, use_c, p, ff_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_prev <= 1'b0;
      ff_q   <= 1'b0;
    end else begin
      b_prev <= p[1];
      ff_q   <= ff_n;
    end
  end

  // R6
  ff_set_chk: assert property (@(posedge clk) disable iff (!rst_n) ff_set |=> ff_q);
  // R6
  ff_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) (ff_clr && !ff_set) |=> !ff_q);
  // R6
  b_edge_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(p[1]) |-> b_rise);

endmodule

// File: rtl/lc_report.sv
module lc_report #(
  parameter int               EVT_W    = 5,
  parameter logic [EVT_W-1:0] EVT_CODE = 5'h11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             f,
  input  logic             inv_out,
  input  logic             out_en,
  input  logic             irq_level,
  input  logic             event_en,
  output logic             y_q,
  output logic             irq,
  output logic             evt_valid,
  output logic [EVT_W-1:0] evt_code
);
  logic y_next;
  logic y_change;
  logic evt_fire;

  assign y_next   = out_en & (f ^ inv_out);
  assign y_change = y_next ^ y_q;
  assign evt_fire = event_en & out_en & y_change;
  assign irq      = out_en & ~(y_q ^ irq_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q       <= 1'b0;
      evt_valid <= 1'b0;
      evt_code  <= '0;
    end else begin
      y_q       <= y_next;
      evt_valid <= evt_fire;
      evt_code  <= evt_fire ? EVT_CODE : '0;
    end
  end

  // R8
  oe_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !out_en |=> !y_q);
  // R8
  irq_oe_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> out_en);
  // R10
  evt_change_chk: assert property (@(posedge clk) disable iff (!rst_n) evt_valid |-> (y_q != $past(y_q)));
  // R10
  evt_code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !evt_valid |-> (evt_code == '0));

endmodule

// File: rtl/tri_logic_cell.sv
module tri_logic_cell
  import lc_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter int               EVT_W       = 5,
  parameter logic [EVT_W-1:0] EVT_CODE    = 5'h11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       in_raw,
  input  logic [2:0]       in_en,
  input  logic [2:0]       in_inv,
  input  logic [2:0]       func_sel,
  input  logic             use_c,
  input  logic             ff_set,
  input  logic             ff_clr,
  input  logic             inv_out,
  input  logic             out_en,
  input  logic             irq_level,
  input  logic             event_en,
  output logic             y_out,
  output logic             irq,
  output logic             evt_valid,
  output logic [EVT_W-1:0] evt_code
);
  logic [LC_NIN-1:0] in_sync;
  logic [LC_NIN-1:0] in_cond;
  logic              fn_res;
  logic              ff_state;
  logic              b_rise;

  lc_sync #(.W(LC_NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (in_raw),
    .q (in_sync)
  );

  for (genvar i = 0; i < LC_NIN; i++) begin : g_cond
    assign in_cond[i] = lc_condition(in_sync[i], in_en[i], in_inv[i]);
  end

  lc_func u_func (
    .clk (clk),
    .rst_n (rst_n),
    .p (in_cond),
    .sel (func_sel),
    .use_c (use_c),
    .ff_set (ff_set),
    .ff_clr (ff_clr),
    .f (fn_res),
    .ff_q (ff_state),
    .b_rise (b_rise)
  );

  lc_report #(.EVT_W(EVT_W), .EVT_CODE(EVT_CODE)) u_report (
    .clk (clk),
    .rst_n (rst_n),
    .f (fn_res),
    .inv_out (inv_out),
    .out_en (out_en),
    .irq_level (irq_level),
    .event_en (event_en),
    .y_q (y_out),
    .irq (irq),
    .evt_valid (evt_valid),
    .evt_code (evt_code)
  );

  // R4
  reserved_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (func_sel inside {3'b101, 3'b110, 3'b111}) |-> !fn_res);

endmodule

// File: tb/tri_logic_cell_test.sv
`timescale 1ns/1ps
module tri_logic_cell_test;
  localparam logic [4:0] CODE = 5'h11;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic [2:0] in_raw, in_en, in_inv, func_sel;
  logic       use_c, ff_set, ff_clr, inv_out, out_en, irq_level, event_en;
  logic       y_out, irq, evt_valid;
  logic [4:0] evt_code;

  tri_logic_cell uut (
    .clk(clk), .rst_n(rst_n), .in_raw(in_raw), .in_en(in_en), .in_inv(in_inv),
    .func_sel(func_sel), .use_c(use_c), .ff_set(ff_set), .ff_clr(ff_clr),
    .inv_out(inv_out), .out_en(out_en), .irq_level(irq_level), .event_en(event_en),
    .y_out(y_out), .irq(irq), .evt_valid(evt_valid), .evt_code(evt_code)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model state
  logic [2:0] m_s1 = '0, m_s2 = '0;
  logic       m_bprev = 1'b0, m_ff = 1'b0, m_y = 1'b0, m_evt = 1'b0;

  function automatic logic exp_fn(input logic [2:0] sel, input logic c_on,
                                  input logic [2:0] p, input logic ffv);
    logic [2:0] used;
    used = c_on ? p : {1'b0, p[1:0]};
    if (sel == 3'd1) return c_on ? (&p) : (&p[1:0]);
    if (sel == 3'd2) return |used;
    if (sel == 3'd3) return ^used;
    if (sel == 3'd4) return ffv;
    return 1'b0;
  endfunction

  task automatic model_step();
    logic [2:0] p;
    logic yn, fn;
    p  = (m_s2 & in_en) ^ in_inv;
    fn = exp_fn(func_sel, use_c, p, m_ff);
    yn = out_en ? (fn ^ inv_out) : 1'b0;
    m_evt = event_en && out_en && (yn != m_y);
    if (ff_set) m_ff = 1'b1;
    else if (ff_clr) m_ff = 1'b0;
    else if (p[1] && !m_bprev) m_ff = p[0];
    m_bprev = p[1];
    m_y  = yn;
    m_s2 = m_s1;
    m_s1 = in_raw;
  endtask

  task automatic chk(input string tag, input string what, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "y_out", {4'b0, y_out}, {4'b0, m_y});
    chk(out_en ? "R9" : "R8", "irq", {4'b0, irq}, {4'b0, (out_en && (m_y == irq_level))});
    chk("R10", "evt_valid", {4'b0, evt_valid}, {4'b0, m_evt});
    chk("R10", "evt_code", evt_code, m_evt ? CODE : 5'h00);
  endtask

  task automatic set_cfg(input int phase);
    in_en = 3'b111; in_inv = 3'($urandom_range(0, 7)); func_sel = 3'($urandom_range(1, 3));
    use_c = 1'b1; ff_set = 1'b0; ff_clr = 1'b0; inv_out = 1'b0; out_en = 1'b1;
    irq_level = 1'($urandom_range(0, 1)); event_en = 1'b1;
    case (phase)
      3: begin in_en = 3'($urandom_range(0, 7)); end
      4: begin func_sel = 3'($urandom_range(0, 7)); end
      5: begin use_c = 1'($urandom_range(0, 1)); end
      6: begin func_sel = 3'd4; ff_set = ($urandom_range(0, 5) == 0); ff_clr = ($urandom_range(0, 4) == 0); end
      7: begin func_sel = 3'($urandom_range(0, 4)); inv_out = 1'($urandom_range(0, 1)); end
      8: begin out_en = 1'($urandom_range(0, 1)); inv_out = 1'($urandom_range(0, 1)); end
      9: begin
        in_en = 3'($urandom_range(0, 7)); func_sel = 3'($urandom_range(0, 7));
        use_c = 1'($urandom_range(0, 1)); ff_set = ($urandom_range(0, 7) == 0);
        ff_clr = ($urandom_range(0, 7) == 0); inv_out = 1'($urandom_range(0, 1));
        out_en = ($urandom_range(0, 5) != 0); event_en = 1'($urandom_range(0, 1));
      end
      default: ;
    endcase
  endtask

  task automatic tick_and_check(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic run(input int n, input int phase, input string tag);
    for (int k = 0; k < n; k++) begin
      if (k % 4 == 0) set_cfg(phase);
      tick_and_check(tag);
      in_raw = 3'($urandom_range(0, 7));
    end
  endtask

  initial begin
    void'($urandom(32'd5172));
    rst_n = 1'b0; in_raw = '0; in_en = 3'b111; in_inv = '0; func_sel = 3'd1;
    use_c = 1'b1; ff_set = 1'b0; ff_clr = 1'b0; inv_out = 1'b1; out_en = 1'b1;
    irq_level = 1'b0; event_en = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state even with inverted output configured
    chk("R1", "y_out", {4'b0, y_out}, 5'h0);
    chk("R1", "evt_valid", {4'b0, evt_valid}, 5'h0);
    chk("R1", "evt_code", evt_code, 5'h0);
    chk("R1", "irq", {4'b0, irq}, 5'h1);
    inv_out = 1'b0;
    rst_n = 1'b1;
    // R2 directed: step all inputs high after settling low
    repeat (4) tick_and_check("R2");
    in_raw = 3'b111;
    tick_and_check("R2");
    chk("R2", "y after 1 edge", {4'b0, y_out}, 5'h0);
    tick_and_check("R2");
    chk("R2", "y after 2 edges", {4'b0, y_out}, 5'h0);
    tick_and_check("R2");
    chk("R2", "y after 3 edges", {4'b0, y_out}, 5'h1);
    chk("R10", "event on rise", {4'b0, evt_valid}, 5'h1);
    // R6 directed: set and clear together -> set wins
    func_sel = 3'd4; ff_set = 1'b1; ff_clr = 1'b1;
    tick_and_check("R6");
    ff_set = 1'b0; ff_clr = 1'b0;
    tick_and_check("R6");
    chk("R6", "set over clear", {4'b0, y_out}, 5'h1);
    ff_clr = 1'b1;
    tick_and_check("R6");
    ff_clr = 1'b0;
    tick_and_check("R6");
    chk("R6", "clear", {4'b0, y_out}, 5'h0);
    // R4 directed: reserved code with all inputs high
    func_sel = 3'd7; inv_out = 1'b0; in_raw = 3'b111;
    repeat (4) tick_and_check("R4");
    chk("R4", "reserved low", {4'b0, y_out}, 5'h0);
    run(300, 3, "R3");
    run(300, 4, "R4");
    run(300, 5, "R5");
    run(400, 6, "R6");
    run(300, 7, "R7");
    run(300, 8, "R8");
    run(600, 9, "R10");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule